// File: doc/BRIEF.md
# Byte SECDED Encoder and Decoder

This block guards one 8-bit byte with a single-error-correcting, double-error-detecting code. The encoder spreads the byte over a 12-bit Hamming word and adds one bit that makes the whole word even. Four check bits sit at the power-of-two positions. The result is a 13-bit codeword. The decoder takes a 13-bit word that may have been disturbed. It forms a 4-bit syndrome that names a position, checks the parity of the whole word, and returns the byte together with a status code.

Both paths are independent and valid-qualified. Each registers its result, so the output appears one clock after the input strobe and holds until the next strobe. A lone flipped bit is repaired, including a flip of the whole-word parity bit itself. Any pair of flipped bits is flagged as uncorrectable, and the byte is then returned exactly as received. An asynchronous active-low reset clears both valid outputs. Its release is synchronised to the clock inside the block.

Top module: `secded_byte_codec`

## Requirements
- R1: Codeword bit k-1 carries Hamming position k for k = 1..12. Check bits sit at positions 1, 2, 4 and 8. Data bits d0..d7 sit at positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. Bit 12 of the codeword is the whole-word parity bit.
- R2: The check bit at position 2^j is the XOR of every other position whose index has bit j set. Every encoded word therefore has a zero syndrome, where the syndrome is the XOR of the indices of all set positions 1..12.
- R3: The whole-word parity bit gives every encoded 13-bit word an even number of ones.
- R4: enc_valid_o follows enc_valid_i one clock later. enc_word_o updates only on a cycle after enc_valid_i was high, and holds its value otherwise.
- R5: dec_valid_o follows dec_valid_i one clock later. dec_data_o and dec_status_o update only on a cycle after dec_valid_i was high, and hold their values otherwise.
- R6: A word with a zero syndrome and even overall parity gives status 2'b00 (clean) and the data bits as received. Status 2'b11 never appears.
- R7: A word with odd overall parity and a syndrome s in 1..12 gives status 2'b01 (corrected), with position s complemented before the data is extracted.
- R8: A word with odd overall parity and a zero syndrome (only bit 12 flipped) gives status 2'b01, with the data unchanged.
- R9: A word with even overall parity and a nonzero syndrome gives status 2'b10 (double error), with the data bits as received and uncorrected.
- R10: A word with odd overall parity and a syndrome of 13, 14 or 15 gives status 2'b10, with the data bits as received and uncorrected.
- R11: While rst_n is low, and after it rises until the first input strobe, enc_valid_o and dec_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | 8 | Byte to encode |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_word_o | output | 13 | Encoded word, bit 12 = whole-word parity |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_word_i | input | 13 | Received word to check |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | 8 | Recovered byte |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 double error |

## Verification
The hardest case to reach is the out-of-range syndrome. The parity is odd, but the syndrome points past position 12. No single or double error can produce it. Only three flips whose position indices XOR to 13, 14 or 15 can. The stimulus builds such triples on purpose, for example positions 1, 4 and 8. It does this next to sweeps of every single flip and every pair of flips, covering the parity bit as well. This gives both the "only the parity bit flipped" case and the "parity bit plus one other bit" case.

// File: rtl/secded_pkg.sv
package secded_pkg;

  typedef enum logic [1:0] {
    DEC_CLEAN  = 2'b00,
    DEC_FIXED  = 2'b01,
    DEC_DOUBLE = 2'b10
  } dec_status_e;

  // Smallest count of check bits c with 2^c >= data + c + 1.
  function automatic int chk_bits_for(input int data_w);
    int c;
    c = 1;
    while ((1 << c) < data_w + c + 1) c++;
    return c;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // 1-based Hamming position of data bit idx.
  function automatic int data_pos(input int idx);
    int seen;
    int p;
    seen = 0;
    p = 0;
    for (int q = 1; q < 128; q++) begin
      if (!is_pow2(q)) begin
        if (seen == idx) begin
          p = q;
          break;
        end
        seen++;
      end
    end
    return p;
  endfunction

  // Positions covered by check bit j within a word of ham_w positions.
  function automatic logic [63:0] cover_mask(input int j, input int ham_w);
    logic [63:0] m;
    m = '0;
    for (int p = 1; p <= ham_w; p++) begin
      if (((p >> j) & 1) == 1) m[p-1] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_scatter.sv
module secded_scatter #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  localparam int HAM_W = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o
);
  // Data bits go to non power-of-two positions; check slots stay zero here.
  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    localparam int POS = secded_pkg::data_pos(i);
    assign ham_o[POS-1] = data_i[i];
  end
  for (genvar j = 0; j < CHK_W; j++) begin : g_slot
    assign ham_o[(1 << j) - 1] = 1'b0;
  end
endmodule

// File: rtl/secded_gather.sv
module secded_gather #(
  parameter int DATA_W = 8,
  parameter int CHK_W  = 4,
  localparam int HAM_W = DATA_W + CHK_W
) (
  input  logic [HAM_W-1:0]  ham_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    int k;
    k = 0;
    data_o = '0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!secded_pkg::is_pow2(p)) begin
        data_o[k] = ham_i[p-1];
        k++;
      end
    end
  end
endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome #(
  parameter int HAM_W = 12,
  parameter int CHK_W = 4
) (
  input  logic [HAM_W-1:0] word_i,
  output logic [CHK_W-1:0] syn_o
);
  for (genvar j = 0; j < CHK_W; j++) begin : g_chk
    localparam logic [63:0] MASK = secded_pkg::cover_mask(j, HAM_W);
    assign syn_o[j] = ^(word_i & MASK[HAM_W-1:0]);
  end
endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int HAM_W = 12,
  parameter int CHK_W = 4
) (
  input  logic [HAM_W-1:0] ham_i,
  input  logic [CHK_W-1:0] syn_i,
  input  logic             par_odd_i,
  output logic [HAM_W-1:0] ham_o,
  output dec_status_e      status_o
);
  logic [HAM_W-1:0] hit;
  logic             in_range;
  logic             repair;

  // One-hot decode of the syndrome onto positions 1..HAM_W.
  for (genvar p = 1; p <= HAM_W; p++) begin : g_hit
    assign hit[p-1] = (syn_i == CHK_W'(p));
  end

  assign in_range = ({1'b0, syn_i} <= (CHK_W+1)'(HAM_W));

  always_comb begin
    repair   = 1'b0;
    status_o = DEC_CLEAN;
    if (!par_odd_i && (syn_i == '0)) begin
      status_o = DEC_CLEAN;
    end else if (par_odd_i && in_range) begin
      status_o = DEC_FIXED;
      repair   = 1'b1;
    end else begin
      status_o = DEC_DOUBLE;
    end
  end

  assign ham_o = ham_i ^ (hit & {HAM_W{repair}});
endmodule

// File: rtl/secded_byte_codec.sv
module secded_byte_codec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = chk_bits_for(DATA_W),
  localparam int HAM_W = DATA_W + CHK_W,
  localparam int CW_W  = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CW_W-1:0]   enc_word_o,
  input  logic              dec_valid_i,
  input  logic [CW_W-1:0]   dec_word_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic [1:0]        dec_status_o
);
  // ---------------- reset release synchroniser ----------------
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // ---------------- encoder path ----------------
  logic [HAM_W-1:0] enc_scat;
  logic [CHK_W-1:0] enc_chk;
  logic [HAM_W-1:0] enc_ham;
  logic [CW_W-1:0]  enc_word_n;
  logic             enc_valid_n;
  logic [CW_W-1:0]  enc_word_q;
  logic             enc_valid_q;

  secded_scatter #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc_scatter (
    .data_i (enc_data_i),
    .ham_o  (enc_scat)
  );

  // Check slots are zero in enc_scat, so its syndrome equals the check bits.
  secded_syndrome #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_enc_syn (
    .word_i (enc_scat),
    .syn_o  (enc_chk)
  );

  always_comb begin
    enc_ham = enc_scat;
    for (int j = 0; j < CHK_W; j++) begin
      enc_ham[(1 << j) - 1] = enc_chk[j];
    end
  end

  always_comb begin
    enc_valid_n = enc_valid_i;
    enc_word_n  = enc_word_q;
    if (enc_valid_i) enc_word_n = {^enc_ham, enc_ham};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) enc_valid_q <= 1'b0;
    else          enc_valid_q <= enc_valid_n;
  end

  always_ff @(posedge clk) begin
    enc_word_q <= enc_word_n;
  end

  assign enc_valid_o = enc_valid_q;
  assign enc_word_o  = enc_word_q;

  // ---------------- decoder path ----------------
  logic [HAM_W-1:0]  dec_ham;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_par_odd;
  logic [HAM_W-1:0]  dec_fixed;
  dec_status_e       dec_stat_c;
  logic [DATA_W-1:0] dec_data_c;
  logic              dec_valid_n;
  logic [DATA_W-1:0] dec_data_n;
  logic [1:0]        dec_stat_n;
  logic              dec_valid_q;
  logic [DATA_W-1:0] dec_data_q;
  logic [1:0]        dec_stat_q;

  assign dec_ham     = dec_word_i[HAM_W-1:0];
  assign dec_par_odd = ^dec_word_i;

  secded_syndrome #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_dec_syn (
    .word_i (dec_ham),
    .syn_o  (dec_syn)
  );

  secded_fix #(.HAM_W(HAM_W), .CHK_W(CHK_W)) u_dec_fix (
    .ham_i     (dec_ham),
    .syn_i     (dec_syn),
    .par_odd_i (dec_par_odd),
    .ham_o     (dec_fixed),
    .status_o  (dec_stat_c)
  );

  secded_gather #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec_gather (
    .ham_i  (dec_fixed),
    .data_o (dec_data_c)
  );

  always_comb begin
    dec_valid_n = dec_valid_i;
    dec_data_n  = dec_data_q;
    dec_stat_n  = dec_stat_q;
    if (dec_valid_i) begin
      dec_data_n = dec_data_c;
      dec_stat_n = dec_stat_c;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) dec_valid_q <= 1'b0;
    else          dec_valid_q <= dec_valid_n;
  end

  always_ff @(posedge clk) begin
    dec_data_q <= dec_data_n;
    dec_stat_q <= dec_stat_n;
  end

  assign dec_valid_o  = dec_valid_q;
  assign dec_data_o   = dec_data_q;
  assign dec_status_o = dec_stat_q;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk #(
  parameter int CW_W = 13
) (
  input logic            clk,
  input logic            rst_q_n,
  input logic            enc_valid_i,
  input logic            enc_valid_o,
  input logic [CW_W-1:0] enc_word_o,
  input logic            dec_valid_i,
  input logic [CW_W-1:0] dec_word_i,
  input logic            dec_valid_o,
  input logic [1:0]      dec_status_o
);
  p_enc_strobe_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    enc_valid_i |=> enc_valid_o);
  p_enc_idle_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !enc_valid_i |=> !enc_valid_o);
  p_enc_even_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    enc_valid_o |-> (^enc_word_o) == 1'b0);
  p_dec_strobe_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    dec_valid_i |=> dec_valid_o);
  p_dec_idle_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dec_valid_i |=> !dec_valid_o);
  p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    dec_valid_o |-> dec_status_o != 2'b11);
  p_odd_flagged_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid_i && (^dec_word_i)) |=> dec_status_o != 2'b00);
  p_even_unfixed_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid_i && !(^dec_word_i)) |=> dec_status_o != 2'b01);
endmodule

bind secded_byte_codec secded_codec_chk #(.CW_W(CW_W)) u_chk (
  .clk          (clk),
  .rst_q_n      (rst_q_n),
  .enc_valid_i  (enc_valid_i),
  .enc_valid_o  (enc_valid_o),
  .enc_word_o   (enc_word_o),
  .dec_valid_i  (dec_valid_i),
  .dec_word_i   (dec_word_i),
  .dec_valid_o  (dec_valid_o),
  .dec_status_o (dec_status_o)
);

// File: tb/secded_byte_codec_tb.sv
`timescale 1ns/1ps
module secded_byte_codec_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enc_valid_i;
  logic [7:0]  enc_data_i;
  logic        enc_valid_o;
  logic [12:0] enc_word_o;
  logic        dec_valid_i;
  logic [12:0] dec_word_i;
  logic        dec_valid_o;
  logic [7:0]  dec_data_o;
  logic [1:0]  dec_status_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  secded_byte_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_word_o(enc_word_o),
    .dec_valid_i(dec_valid_i), .dec_word_i(dec_word_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_status_o(dec_status_o)
  );

  // ---------------- reference model ----------------
  function automatic bit pow2(int v);
    return (v & (v - 1)) == 0;
  endfunction

  function automatic int syn_of(logic [12:0] w);
    int s = 0;
    for (int p = 1; p <= 12; p++) if (w[p-1]) s = s ^ p;
    return s;
  endfunction

  function automatic logic [12:0] ref_enc(logic [7:0] d);
    logic [12:0] w = '0;
    int k = 0;
    int s;
    for (int p = 1; p <= 12; p++) if (!pow2(p)) begin w[p-1] = d[k]; k++; end
    s = syn_of(w);
    for (int j = 0; j < 4; j++) w[(1 << j) - 1] = s[j];
    w[12] = ^w[11:0];
    return w;
  endfunction

  function automatic logic [7:0] raw_data(logic [12:0] w);
    logic [7:0] d = '0;
    int k = 0;
    for (int p = 1; p <= 12; p++) if (!pow2(p)) begin d[k] = w[p-1]; k++; end
    return d;
  endfunction

  logic        e_enc_v, e_dec_v, enc_seen, dec_seen;
  logic [12:0] e_enc_w;
  logic [7:0]  e_dec_d;
  logic [1:0]  e_dec_s;
  string       e_tag;

  task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit ev, logic [7:0] ed, bit dv, logic [12:0] dw, string tag);
    enc_valid_i = ev; enc_data_i = ed; dec_valid_i = dv; dec_word_i = dw;
    e_enc_v = ev;
    if (ev) begin e_enc_w = ref_enc(ed); enc_seen = 1'b1; end
    e_dec_v = dv;
    if (dv) begin
      int s = syn_of(dw);
      bit odd = ^dw;
      logic [12:0] w = dw;
      dec_seen = 1'b1;
      e_tag = tag;
      if (s == 0 && !odd) e_dec_s = 2'b00;
      else if (odd && s <= 12) begin
        e_dec_s = 2'b01;
        if (s != 0) w[s-1] = ~w[s-1];
      end else e_dec_s = 2'b10;
      e_dec_d = raw_data(w);
    end
    @(negedge clk);
    chk(enc_valid_o == e_enc_v, "R4 enc_valid", 16'(enc_valid_o), 16'(e_enc_v));
    if (enc_seen) chk(enc_word_o == e_enc_w, ev ? "R1 enc_word" : "R4 enc_word hold",
                      16'(enc_word_o), 16'(e_enc_w));
    if (ev) begin
      chk((^enc_word_o) == 1'b0, "R3 even word", 16'(^enc_word_o), 16'h0);
      chk(syn_of(enc_word_o) == 0, "R2 zero syndrome", 16'(syn_of(enc_word_o)), 16'h0);
    end
    chk(dec_valid_o == e_dec_v, "R5 dec_valid", 16'(dec_valid_o), 16'(e_dec_v));
    if (dec_seen) begin
      chk(dec_status_o == e_dec_s, dv ? {e_tag, " status"} : "R5 status hold",
          16'(dec_status_o), 16'(e_dec_s));
      chk(dec_data_o == e_dec_d, dv ? {e_tag, " data"} : "R5 data hold",
          16'(dec_data_o), 16'(e_dec_d));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    enc_seen = 0; dec_seen = 0;
    enc_valid_i = 0; enc_data_i = '0; dec_valid_i = 0; dec_word_i = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(enc_valid_o == 1'b0, "R11 enc_valid in reset", 16'(enc_valid_o), 16'h0);
    chk(dec_valid_o == 1'b0, "R11 dec_valid in reset", 16'(dec_valid_o), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(enc_valid_o == 1'b0, "R11 enc_valid after release", 16'(enc_valid_o), 16'h0);
    chk(dec_valid_o == 1'b0, "R11 dec_valid after release", 16'(dec_valid_o), 16'h0);

    // All bytes encoded; each clean codeword decoded (R1, R6).
    for (int d = 0; d < 256; d++) begin
      logic [12:0] w = ref_enc(8'(d));
      step(1'b1, 8'(d), 1'b1, w, "R6");
    end

    // Idle gaps: outputs must hold (R4, R5).
    step(1'b1, 8'hA5, 1'b1, ref_enc(8'h3C) ^ 13'h0004, "R7");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h5A, 1'b0, 13'h1FFF, "R5");

    // Every single flip (R7 for positions 1..12, R8 for the parity bit).
    for (int k = 0; k < 64; k++) begin
      logic [7:0] d = 8'((k * 37 + 11) & 255);
      for (int b = 0; b < 13; b++) begin
        logic [12:0] w = ref_enc(d);
        w[b] = ~w[b];
        step(1'b0, 8'h00, 1'b1, w, (b == 12) ? "R8" : "R7");
      end
    end

    // Every pair of flips (R9).
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d = 8'((k * 73 + 5) & 255);
      for (int a = 0; a < 13; a++)
        for (int b = a + 1; b < 13; b++) begin
          logic [12:0] w = ref_enc(d);
          w[a] = ~w[a]; w[b] = ~w[b];
          step(1'b1, d, 1'b1, w, "R9");
        end
    end

    // Triples whose indices XOR past 12 (R10): {1,4,8}=13 {2,4,8}=14 {3,6,10}=15 {3,5,9}=15.
    for (int k = 0; k < 32; k++) begin
      logic [7:0] d = 8'((k * 29 + 3) & 255);
      for (int t = 0; t < 4; t++) begin
        logic [12:0] w = ref_enc(d);
        case (t)
          0: w = w ^ 13'b0_0000_1000_1001;
          1: w = w ^ 13'b0_0000_1000_1010;
          2: w = w ^ 13'b0_0010_0010_0100;
          default: w = w ^ 13'b0_0001_0001_0100;
        endcase
        step(1'b0, 8'h00, 1'b1, w, "R10");
      end
    end

    step(1'b0, 8'h00, 1'b0, 13'h0, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule